// File: doc/BRIEF.md
# Associative Array with Masked Search

This block is a small content-addressed storage array. Every stored word carries its own comparison logic and a one-bit mark flag. A host first loads a comparand register and a mask register through a command port. It then issues a masked search, which compares the selected bit positions of all words against the comparand in one clock and records the outcome in the mark flags. A later parallel write uses those marks as its selector and stores the comparand's selected bits into every marked word at once. The array can therefore be updated in bulk by content, not only searched.

An ordinary addressed write port and a registered addressed read port give normal access by location. These ports run independently of the command port. Summary outputs report how many words are marked, whether any word is marked, and the lowest marked index.

Top module: `assocArray`

## Requirements
- R1: After reset every word, every mark, the comparand and the mask are zero, so marks=0, matchCount=0, anyMatch=0, firstAddr=0 and rdData=0.
- R2: cmd code 1 loads cmdData into the comparand and cmd code 2 loads cmdData into the mask. A mask bit of 1 makes that bit position take part in a search.
- R3: cmd code 3 performs a search in one cycle. After that edge, mark i is 1 exactly when word i, as held before the edge, equals the comparand on every bit where the mask is 1. An all-zero mask marks every word.
- R4: cmd code 4 (parallel write) replaces the mask-selected bits of every marked word with the comparand's bits and keeps that word's other bits. Unmarked words and the marks themselves stay unchanged, so with no word marked nothing changes.
- R5: cmd code 5 clears every mark. Codes 0, 6 and 7 change neither storage, comparand, mask nor marks.
- R6: When wrEn is 1, word wrAddr takes wrData and its mark becomes 0 at the same edge. This overrides a search or a parallel write issued in the same cycle for that word only.
- R7: rdData shows the word at rdAddr as it was held before the previous edge (one cycle of latency).
- R8: matchCount equals the number of set marks, anyMatch is 1 when at least one mark is set, and firstAddr is the lowest marked index, or 0 when none is set.
- R9: Marks keep their value in every cycle with no search, no clear and no addressed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| cmd | input | 3 | Command code (0 idle, 1 load comparand, 2 load mask, 3 search, 4 parallel write, 5 clear marks) |
| cmdData | input | WORD_W | Value for the load commands |
| wrEn | input | 1 | Addressed write enable |
| wrAddr | input | $clog2(DEPTH) | Addressed write location |
| wrData | input | WORD_W | Addressed write value |
| rdAddr | input | $clog2(DEPTH) | Addressed read location |
| rdData | output | WORD_W | Registered read value |
| marks | output | DEPTH | Per-word mark flags |
| matchCount | output | $clog2(DEPTH+1) | Number of marked words |
| anyMatch | output | 1 | At least one word marked |
| firstAddr | output | $clog2(DEPTH) | Lowest marked index |

## Verification
An addressed write can fall in the same cycle as a search or as a parallel write, and can hit the very word that the content-driven operation would otherwise mark or overwrite. The bench provokes this on purpose: it writes to a word that the simultaneous search would match, and it writes to a word that is marked while a parallel write is issued. It then judges the mark and the read-back contents against a behavioural model, in which the addressed write wins for that word and every other word follows the content operation. A long random phase also mixes both ports freely, so the overlap recurs with arbitrary addresses.

// File: rtl/assocPkg.sv
package assocPkg;
  typedef enum logic [2:0] {
    CMD_IDLE   = 3'd0,
    CMD_LDCMP  = 3'd1,
    CMD_LDMASK = 3'd2,
    CMD_SEARCH = 3'd3,
    CMD_PWRITE = 3'd4,
    CMD_CLEAR  = 3'd5
  } cmdCode_e;

  typedef struct packed {
    logic ldCmp;
    logic ldMask;
    logic search;
    logic pwrite;
    logic clrMarks;
  } ctlStrobes_t;
endpackage

// File: rtl/assocCtrl.sv
module assocCtrl
  import assocPkg::*;
(
  input  logic [2:0]  cmd,
  output ctlStrobes_t ctl
);
  always_comb begin
    ctl = '0;
    case (cmd)
      CMD_LDCMP:  ctl.ldCmp    = 1'b1;
      CMD_LDMASK: ctl.ldMask   = 1'b1;
      CMD_SEARCH: ctl.search   = 1'b1;
      CMD_PWRITE: ctl.pwrite   = 1'b1;
      CMD_CLEAR:  ctl.clrMarks = 1'b1;
      default:    ctl = '0;
    endcase
  end
endmodule

// File: rtl/assocDatapath.sv
module assocDatapath
  import assocPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [DEPTH-1:0]  marks
);
  logic [WORD_W-1:0] words [DEPTH];
  logic [WORD_W-1:0] cmpReg;
  logic [WORD_W-1:0] maskReg;
  logic [DEPTH-1:0]  hit;

  // per-word comparison logic
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hit[g] = ~|((words[g] ^ cmpReg) & maskReg);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg  <= '0;
      maskReg <= '0;
    end else begin
      if (ctl.ldCmp)  cmpReg  <= cmdData;
      if (ctl.ldMask) maskReg <= cmdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        words[i] <= '0;
        marks[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wrEn && (wrAddr == AW'(i))) begin
          words[i] <= wrData;
          marks[i] <= 1'b0;
        end else begin
          if (ctl.pwrite && marks[i])
            words[i] <= (words[i] & ~maskReg) | (cmpReg & maskReg);
          if (ctl.search)
            marks[i] <= hit[i];
          else if (ctl.clrMarks)
            marks[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= words[rdAddr];
  end
endmodule

// File: rtl/assocSummary.sv
module assocSummary #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
)(
  input  logic [DEPTH-1:0] marks,
  output logic [CW-1:0]    matchCount,
  output logic             anyMatch,
  output logic [AW-1:0]    firstAddr
);
  always_comb begin
    matchCount = '0;
    for (int i = 0; i < DEPTH; i++)
      matchCount = matchCount + CW'(marks[i]);
  end

  always_comb begin
    firstAddr = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (marks[i]) firstAddr = AW'(i);
  end

  assign anyMatch = |marks;
endmodule

// File: rtl/assocArray.sv
module assocArray
  import assocPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmd,
  input  logic [WORD_W-1:0] cmdData,
  input  logic              wrEn,
  input  logic [AW-1:0]     wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [WORD_W-1:0] rdData,
  output logic [DEPTH-1:0]  marks,
  output logic [CW-1:0]     matchCount,
  output logic              anyMatch,
  output logic [AW-1:0]     firstAddr
);
  ctlStrobes_t ctl;

  assocCtrl u_ctrl (.cmd(cmd), .ctl(ctl));

  assocDatapath #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .cmdData(cmdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .marks(marks)
  );

  assocSummary #(.DEPTH(DEPTH)) u_sum (
    .marks(marks), .matchCount(matchCount),
    .anyMatch(anyMatch), .firstAddr(firstAddr)
  );
endmodule

// File: rtl/assocArrayChk.sv
module assocArrayChk #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
)(
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       cmd,
  input logic             wrEn,
  input logic [AW-1:0]    wrAddr,
  input logic [DEPTH-1:0] marks,
  input logic [CW-1:0]    matchCount,
  input logic             anyMatch,
  input logic [AW-1:0]    firstAddr
);
  logic [DEPTH-1:0] below;
  always_comb
    for (int k = 0; k < DEPTH; k++) below[k] = (k < int'(firstAddr));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == 3'd5 && !wrEn) |=> (marks == '0));

  p_wr_unmark_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !marks[$past(wrAddr)]);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && cmd != 3'd3 && cmd != 3'd5) |=> $stable(marks));

  p_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    matchCount == CW'($countones(marks)));

  p_any_r8: assert property (@(posedge clk) disable iff (!rstN)
    anyMatch |-> marks[firstAddr]);

  p_none_r8: assert property (@(posedge clk) disable iff (!rstN)
    !anyMatch |-> (marks == '0 && firstAddr == '0));

  p_first_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (marks & below) == '0);
endmodule

bind assocArray assocArrayChk #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .cmd(cmd), .wrEn(wrEn), .wrAddr(wrAddr),
  .marks(marks), .matchCount(matchCount), .anyMatch(anyMatch),
  .firstAddr(firstAddr)
);

// File: tb/test_assocArray.sv
`timescale 1ns/1ps
module test_assocArray;
  localparam int W = 16;
  localparam int D = 16;
  localparam int AW = 4;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmd = '0;
  logic [W-1:0] cmdData = '0;
  logic wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [W-1:0] rdData;
  logic [D-1:0] marks;
  logic [CW-1:0] matchCount;
  logic anyMatch;
  logic [AW-1:0] firstAddr;

  always #5 clk = ~clk;

  assocArray #(.WORD_W(W), .DEPTH(D)) i_assocArray (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdData(cmdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .marks(marks), .matchCount(matchCount),
    .anyMatch(anyMatch), .firstAddr(firstAddr)
  );

  // behavioural reference state
  logic [W-1:0] mMem [D];
  logic [D-1:0] mMark;
  logic [W-1:0] mCmp, mMask, mRd;
  int nChecks = 0;
  int nFail = 0;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic chkOutputs(input string tag);
    int first;
    first = 0;
    for (int i = D - 1; i >= 0; i--) if (mMark[i]) first = i;
    chk(tag, "marks", 32'(marks), 32'(mMark));
    chk("R7", "rdData", 32'(rdData), 32'(mRd));
    chk("R8", "matchCount", 32'(matchCount), 32'($countones(mMark)));
    chk("R8", "anyMatch", 32'(anyMatch), 32'(mMark != '0));
    chk("R8", "firstAddr", 32'(firstAddr), 32'(first));
  endtask

  // one clock: drive after negedge, model next state, compare after posedge
  task automatic step(input logic [2:0] c, input logic [W-1:0] cd,
                      input logic we, input logic [AW-1:0] wa,
                      input logic [W-1:0] wd, input logic [AW-1:0] ra,
                      input string tag);
    logic [W-1:0] nMem [D];
    logic [D-1:0] nMark;
    logic [W-1:0] nCmp, nMask;
    cmd = c; cmdData = cd; wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra;
    for (int i = 0; i < D; i++) nMem[i] = mMem[i];
    nMark = mMark; nCmp = mCmp; nMask = mMask;
    case (c)
      3'd1: nCmp = cd;
      3'd2: nMask = cd;
      3'd3: for (int i = 0; i < D; i++)
              nMark[i] = (((mMem[i] ^ mCmp) & mMask) == '0);
      3'd4: for (int i = 0; i < D; i++)
              if (mMark[i]) nMem[i] = (mMem[i] & ~mMask) | (mCmp & mMask);
      3'd5: nMark = '0;
      default: ;
    endcase
    if (we) begin
      nMem[wa] = wd;
      nMark[wa] = 1'b0;
    end
    @(posedge clk);
    mRd = mMem[ra];
    for (int i = 0; i < D; i++) mMem[i] = nMem[i];
    mMark = nMark; mCmp = nCmp; mMask = nMask;
    #2;
    chkOutputs(tag);
    @(negedge clk);
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < D; i++) step(3'd0, '0, 1'b0, '0, '0, AW'(i), tag);
    step(3'd0, '0, 1'b0, '0, '0, '0, tag);
  endtask

  initial begin
    #(200000 * 10);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mMem[i] = '0;
    mMark = '0; mCmp = '0; mMask = '0; mRd = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chkOutputs("R1");
    readAll("R1");

    // fill by address: upper byte = i mod 4, lower byte = i
    for (int i = 0; i < D; i++)
      step(3'd0, '0, 1'b1, AW'(i), {8'(i % 4), 8'(i)}, '0, "R6");

    // search on upper byte == 2
    step(3'd1, 16'h0200, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'hFF00, 1'b0, '0, '0, '0, "R2");
    step(3'd3, '0, 1'b0, '0, '0, '0, "R3");
    chk("R3", "marks upper==2", 32'(marks), 32'h4444);

    // parallel write: lower nibble := A in marked words
    step(3'd1, 16'h000A, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'h000F, 1'b0, '0, '0, '0, "R2");
    step(3'd4, '0, 1'b0, '0, '0, '0, "R4");
    readAll("R4");

    // exact search on a rewritten word
    step(3'd1, 16'h020A, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'hFFFF, 1'b0, '0, '0, '0, "R2");
    step(3'd3, '0, 1'b0, '0, '0, '0, "R3");

    // all-zero mask marks every word
    step(3'd2, 16'h0000, 1'b0, '0, '0, '0, "R3");
    step(3'd3, '0, 1'b0, '0, '0, '0, "R3");
    chk("R3", "zero mask all marked", 32'(marks), 32'hFFFF);

    // idle codes and hold
    step(3'd6, 16'h1234, 1'b0, '0, '0, '0, "R5");
    step(3'd7, 16'h5678, 1'b0, '0, '0, '0, "R5");
    step(3'd0, '0, 1'b0, '0, '0, '0, "R9");

    // clear, then parallel write with nothing marked
    step(3'd5, '0, 1'b0, '0, '0, '0, "R5");
    step(3'd1, 16'hFFFF, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'hFFFF, 1'b0, '0, '0, '0, "R2");
    step(3'd4, '0, 1'b0, '0, '0, '0, "R4");
    readAll("R4");

    // search that finds nothing
    step(3'd3, '0, 1'b0, '0, '0, '0, "R8");
    chk("R8", "no match count", 32'(matchCount), 32'd0);

    // collision: search + addressed write to a word it would match
    step(3'd1, 16'h0300, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'hFF00, 1'b0, '0, '0, '0, "R2");
    step(3'd3, '0, 1'b1, AW'(7), 16'h03EE, '0, "R6");
    chk("R6", "written word unmarked", 32'(marks[7]), 32'd0);

    // collision: parallel write + addressed write to a marked word
    step(3'd1, 16'h00C0, 1'b0, '0, '0, '0, "R2");
    step(3'd2, 16'h00F0, 1'b0, '0, '0, '0, "R2");
    step(3'd4, '0, 1'b1, AW'(11), 16'hBEEF, '0, "R6");
    readAll("R6");

    // random mix of both ports
    for (int n = 0; n < 400; n++)
      step(3'($urandom_range(0, 7)), 16'($urandom), ($urandom_range(0, 3) == 0),
           AW'($urandom), 16'($urandom & 32'h0F0F), AW'($urandom), "R9");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule